// File: doc/BRIEF.md
# Banked Internal Data RAM with Hardware Stack

This block holds the 128-byte on-chip data memory of an 8-bit microcontroller core and resolves every way the core names a byte in it. A register operand (one of eight working registers) is turned into a RAM address through a two-bit bank select. A direct operand carries a 7-bit address. An indirect operand uses working register 0 or 1 of the active bank as a pointer. Push and pop go through an 8-bit stack pointer that lives beside the array and starts at 07h, so the stack grows upward through the same RAM.

The core presents one access per cycle: an addressing mode, the operand fields, and one or two of the read, write, push and pop strobes. Read data and the error pulse are registered, so they appear one cycle after the strobe. Any pointer or stack address at or above the array depth is refused. It reads as zero, writes nothing and raises a one-cycle error flag.

Top module: `idata_bank_ram`

## Requirements
- R1: While reset is high, and in the first cycle after it, `stack_ptr` is 07h, `rd_data` is 00h, `range_err` is 0, and every RAM byte reads 00h.
- R2: With `acc_mode` = 0 (register), register `reg_idx` of bank `bank_sel` maps to address `bank_sel`*8 + `reg_idx`. Bank 0 starts at 00h, bank 1 at 08h, bank 2 at 10h and bank 3 at 18h.
- R3: With `acc_mode` = 1 (direct), `dir_addr` names any byte from 00h to 7Fh.
- R4: With `acc_mode` = 2 (indirect), the byte in register 0 (`reg_idx[0]` = 0) or register 1 (`reg_idx[0]` = 1) of the active bank is the target address. Pointer values up to 7Fh are served.
- R5: An indirect access whose pointer is 80h or above returns 00h on a read and changes no byte on a write.
- R6: A push first increments `stack_ptr` and then stores `wr_data` at the new value, so the first push after reset lands at 08h. With no push or pop, `stack_ptr` holds.
- R7: A pop loads the byte at the current `stack_ptr` into `rd_data` and then decrements the pointer. A pop at 00h leaves it at FFh.
- R8: A push whose incremented pointer would be 80h or above, or a pop whose pointer is 80h or above, leaves `stack_ptr` unchanged and writes nothing. Such a pop returns 00h.
- R9: When a read and a write name the same byte in one cycle, `rd_data` returns the old contents and the new value is stored.
- R10: `rd_data` updates at the clock edge that samples `rd_en` or `pop_en`, and holds its value in every other cycle.
- R11: When a push or pop is strobed, a read or write strobed in the same cycle is ignored.
- R12: `range_err` is high for exactly the cycle after each refused access (R5, R8) and low after an accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_mode | input | 2 | 0 register, 1 direct, 2 indirect (3 behaves as direct) |
| reg_idx | input | 3 | Working register number; bit 0 picks the pointer register in indirect mode |
| dir_addr | input | 7 | Direct byte address |
| bank_sel | input | 2 | Active register bank (upper status bit is the MSB) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| push_en | input | 1 | Push strobe; never together with pop_en |
| pop_en | input | 1 | Pop strobe |
| wr_data | input | 8 | Data for writes and pushes |
| rd_data | output | 8 | Registered read or pop result |
| stack_ptr | output | 8 | Current stack pointer |
| range_err | output | 1 | One-cycle flag for a refused access |

## Verification
The bench builds the block with its defaults: 8-bit data, a depth of 128, four banks of eight registers and a stack reset value of 07h. At this depth, 127 pushes from 00h carry the stack pointer to the 7Fh ceiling, so the overflow refusal can be reached in a short run. Eight pops from reset reach the FFh wrap and the pop refusal that follows it. Pointers of 7Fh and 90h sit on both sides of the indirect limit, and the stack value 99h left in bank 1 doubles as a refused pointer.

// File: rtl/dram_pkg.sv
package dram_pkg;

    // Default geometry of the internal data memory
    localparam int unsigned DRAM_DW    = 8;
    localparam int unsigned DRAM_DEPTH = 128;
    localparam int unsigned DRAM_NBANK = 4;
    localparam int unsigned DRAM_NREG  = 8;
    localparam logic [7:0]  DRAM_SP_RST = 8'h07;

    // Operand addressing kinds presented by the core
    typedef enum logic [1:0] {
        AM_REG = 2'd0,
        AM_DIR = 2'd1,
        AM_IND = 2'd2,
        AM_RSV = 2'd3
    } amode_e;

    // Raw strobes of one cycle
    typedef struct packed {
        logic rd;
        logic wr;
        logic push;
        logic pop;
    } strobe_t;

    // Resolved access after arbitration
    typedef struct packed {
        logic rd;
        logic wr;
        logic oor;
    } acc_t;

    // True when a byte-wide address falls inside the array
    function automatic logic addr_in_range(input int unsigned addr, input int unsigned depth);
        return addr < depth;
    endfunction

endpackage

// File: rtl/dram_addr_gen.sv
module dram_addr_gen
    import dram_pkg::*;
#(
    parameter int unsigned DW     = DRAM_DW,
    parameter int unsigned AW     = 7,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned IDX_W  = 3
) (
    input  amode_e            mode,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [AW-1:0]     dir_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DW-1:0]     ptr_val,
    output logic [AW-1:0]     ptr_addr,
    output logic [DW-1:0]     tgt_addr
);

    localparam int unsigned REG_AW = BANK_W + IDX_W;

    logic [REG_AW-1:0] reg_loc;
    logic [REG_AW-1:0] ptr_loc;

    always_comb begin
        // bank selects the upper bits, register number the lower bits
        reg_loc  = {bank_sel, reg_idx};
        ptr_loc  = {bank_sel, {(IDX_W-1){1'b0}}, reg_idx[0]};
        ptr_addr = AW'(ptr_loc);
        unique case (mode)
            AM_REG:  tgt_addr = DW'(reg_loc);
            AM_IND:  tgt_addr = ptr_val;
            default: tgt_addr = DW'(dir_addr);
        endcase
    end

endmodule

// File: rtl/dram_stack_ctrl.sv
module dram_stack_ctrl
    import dram_pkg::*;
#(
    parameter int unsigned    DW     = DRAM_DW,
    parameter int unsigned    DEPTH  = DRAM_DEPTH,
    parameter logic [DW-1:0]  SP_RST = DRAM_SP_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] stk_addr,
    output logic          stk_oor
);

    logic [DW-1:0] sp_inc;
    logic [DW-1:0] sp_dec;

    always_comb begin
        sp_inc   = sp + 1'b1;
        sp_dec   = sp - 1'b1;
        // pre-increment on push, current slot on pop
        stk_addr = push ? sp_inc : sp;
        stk_oor  = (push | pop) & ~addr_in_range(int'(stk_addr), DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_RST;
        end else if (push && !stk_oor) begin
            sp <= sp_inc;
        end else if (pop && !stk_oor) begin
            sp <= sp_dec;
        end
    end

endmodule

// File: rtl/dram_store.sv
module dram_store
    import dram_pkg::*;
#(
    parameter int unsigned DW           = DRAM_DW,
    parameter int unsigned DEPTH        = DRAM_DEPTH,
    parameter int unsigned AW           = 7,
    parameter bit          CLEAR_ON_RST = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);

    logic [DW-1:0] mem [DEPTH];

    generate
        if (CLEAR_ON_RST) begin : g_clear
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(DEPTH); i++) begin
                        mem[i] <= '0;
                    end
                end else if (we) begin
                    mem[waddr] <= wdata;
                end
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (we && !rst) begin
                    mem[waddr] <= wdata;
                end
            end
        end
    endgenerate

    // port A fetches the pointer register, port B the target byte
    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

endmodule

// File: rtl/idata_bank_ram.sv
module idata_bank_ram
    import dram_pkg::*;
#(
    parameter int unsigned   DW     = DRAM_DW,
    parameter int unsigned   DEPTH  = DRAM_DEPTH,
    parameter int unsigned   NBANK  = DRAM_NBANK,
    parameter int unsigned   NREG   = DRAM_NREG,
    parameter logic [DW-1:0] SP_RST = DRAM_SP_RST
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 acc_mode,
    input  logic [$clog2(NREG)-1:0]    reg_idx,
    input  logic [$clog2(DEPTH)-1:0]   dir_addr,
    input  logic [$clog2(NBANK)-1:0]   bank_sel,
    input  logic                       rd_en,
    input  logic                       wr_en,
    input  logic                       push_en,
    input  logic                       pop_en,
    input  logic [DW-1:0]              wr_data,
    output logic [DW-1:0]              rd_data,
    output logic [DW-1:0]              stack_ptr,
    output logic                       range_err
);

    localparam int unsigned AW     = $clog2(DEPTH);
    localparam int unsigned BANK_W = $clog2(NBANK);
    localparam int unsigned IDX_W  = $clog2(NREG);

    amode_e        mode;
    strobe_t       stb;
    acc_t          acc;
    logic          stack_op;
    logic [AW-1:0] ptr_addr;
    logic [DW-1:0] ptr_val;
    logic [DW-1:0] tgt_addr;
    logic [DW-1:0] stk_addr;
    logic          stk_oor;
    logic [DW-1:0] acc_addr;
    logic [DW-1:0] cell_data;
    logic [DW-1:0] rd_q;
    logic          err_q;

    assign mode = amode_e'(acc_mode);
    assign stb  = '{rd: rd_en, wr: wr_en, push: push_en, pop: pop_en};

    dram_addr_gen #(
        .DW(DW), .AW(AW), .BANK_W(BANK_W), .IDX_W(IDX_W)
    ) u_addr (
        .mode     (mode),
        .reg_idx  (reg_idx),
        .dir_addr (dir_addr),
        .bank_sel (bank_sel),
        .ptr_val  (ptr_val),
        .ptr_addr (ptr_addr),
        .tgt_addr (tgt_addr)
    );

    dram_stack_ctrl #(
        .DW(DW), .DEPTH(DEPTH), .SP_RST(SP_RST)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (stb.push),
        .pop      (stb.pop),
        .sp       (stack_ptr),
        .stk_addr (stk_addr),
        .stk_oor  (stk_oor)
    );

    always_comb begin
        stack_op = stb.push | stb.pop;
        acc_addr = stack_op ? stk_addr : tgt_addr;
        // stack strobes take the single access slot
        acc.rd   = stb.pop  | (stb.rd & ~stack_op);
        acc.wr   = stb.push | (stb.wr & ~stack_op);
        acc.oor  = (acc.rd | acc.wr) &
                   (stack_op ? stk_oor : ~addr_in_range(int'(acc_addr), DEPTH));
    end

    dram_store #(
        .DW(DW), .DEPTH(DEPTH), .AW(AW), .CLEAR_ON_RST(1'b1)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (ptr_addr),
        .ra_data (ptr_val),
        .rb_addr (acc_addr[AW-1:0]),
        .rb_data (cell_data),
        .we      (acc.wr & ~acc.oor),
        .waddr   (acc_addr[AW-1:0]),
        .wdata   (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= acc.oor;
            if (acc.rd) begin
                rd_q <= acc.oor ? '0 : cell_data;
            end
        end
    end

    assign rd_data   = rd_q;
    assign range_err = err_q;

endmodule

// File: rtl/idata_bank_ram_chk.sv
module idata_bank_ram_chk #(
    parameter int unsigned   DW     = 8,
    parameter int unsigned   DEPTH  = 128,
    parameter logic [DW-1:0] SP_RST = 8'h07
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic          wr_en,
    input logic          push_en,
    input logic          pop_en,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] stack_ptr,
    input logic          range_err
);

    logic [DW-1:0] sp_up;
    logic [DW-1:0] sp_dn;
    logic          push_ok;
    logic          pop_ok;

    assign sp_up   = stack_ptr + 1'b1;
    assign sp_dn   = stack_ptr - 1'b1;
    assign push_ok = int'(sp_up) < int'(DEPTH);
    assign pop_ok  = int'(stack_ptr) < int'(DEPTH);

    // R1: reset values visible in the first cycle after reset
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stack_ptr == SP_RST && rd_data == '0 && !range_err));

    // R6: accepted push moves the pointer up by one
    p_push_step_r6: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && push_ok) |=> stack_ptr == $past(sp_up));

    // R6: pointer holds without stack strobes
    p_sp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!push_en && !pop_en) |=> $stable(stack_ptr));

    // R7: accepted pop moves the pointer down by one
    p_pop_step_r7: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && pop_ok) |=> stack_ptr == $past(sp_dn));

    // R8: refused stack access keeps the pointer and flags an error
    p_stack_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        ((push_en && !push_ok) || (pop_en && !push_en && !pop_ok)) |=> ($stable(stack_ptr) && range_err));

    // R8: refused pop returns zero
    p_pop_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && !pop_ok) |=> rd_data == '0);

    // R10: read data holds without a read or pop
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !pop_en) |=> $stable(rd_data));

    // R11: push and pop never share a cycle
    p_stack_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(push_en && pop_en));

    // R12: an error pulse always follows some access strobe
    p_err_cause_r12: assert property (@(posedge clk) disable iff (rst)
        range_err |-> $past(rd_en || wr_en || push_en || pop_en));

endmodule

bind idata_bank_ram idata_bank_ram_chk #(
    .DW(DW), .DEPTH(DEPTH), .SP_RST(SP_RST)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .rd_data   (rd_data),
    .stack_ptr (stack_ptr),
    .range_err (range_err)
);

// File: tb/test_idata_bank_ram.sv
module test_idata_bank_ram;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 33;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] idx;
        logic [6:0] dir;
        logic [1:0] bank;
        logic       rd;
        logic       wr;
        logic       push;
        logic       pop;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] erd;
        logic [7:0] esp;
        logic       eerr;
        logic [7:0] req;
    } vec_t;

    // mode idx dir bank rd wr push pop wd | chk erd esp eerr req
    localparam vec_t VECS [NVEC] = '{
        '{2'd0,3'd3,7'h00,2'd2,1'b0,1'b1,1'b0,1'b0,8'hA5, 1'b0,8'h00,8'h07,1'b0,8'd2},  // R2 write R3 of bank 2
        '{2'd1,3'd0,7'h13,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'hA5,8'h07,1'b0,8'd2},  // R2 seen at 13h
        '{2'd0,3'd1,7'h00,2'd0,1'b0,1'b1,1'b0,1'b0,8'h40, 1'b0,8'h00,8'h07,1'b0,8'd4},  // R4 pointer R1 bank 0 = 40h
        '{2'd1,3'd0,7'h40,2'd0,1'b0,1'b1,1'b0,1'b0,8'h5C, 1'b0,8'h00,8'h07,1'b0,8'd3},  // R3 direct write
        '{2'd2,3'd1,7'h00,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h5C,8'h07,1'b0,8'd4},  // R4 indirect read
        '{2'd2,3'd1,7'h00,2'd0,1'b0,1'b1,1'b0,1'b0,8'h77, 1'b0,8'h00,8'h07,1'b0,8'd4},  // R4 indirect write
        '{2'd1,3'd0,7'h40,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h77,8'h07,1'b0,8'd3},  // R3 direct read back
        '{2'd0,3'd0,7'h00,2'd0,1'b0,1'b1,1'b0,1'b0,8'h90, 1'b0,8'h00,8'h07,1'b0,8'd5},  // R5 pointer R0 = 90h
        '{2'd2,3'd0,7'h00,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h00,8'h07,1'b1,8'd5},  // R5 refused read
        '{2'd2,3'd0,7'h00,2'd0,1'b0,1'b1,1'b0,1'b0,8'h11, 1'b0,8'h00,8'h07,1'b1,8'd5},  // R5 refused write
        '{2'd1,3'd0,7'h10,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h00,8'h07,1'b0,8'd5},  // R5 alias 10h untouched, R12 flag low
        '{2'd0,3'd0,7'h00,2'd0,1'b0,1'b0,1'b1,1'b0,8'h3C, 1'b0,8'h00,8'h08,1'b0,8'd6},  // R6 first push
        '{2'd1,3'd0,7'h08,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h3C,8'h08,1'b0,8'd6},  // R6 lands at 08h
        '{2'd0,3'd0,7'h00,2'd0,1'b0,1'b0,1'b1,1'b0,8'h4D, 1'b0,8'h00,8'h09,1'b0,8'd6},  // R6 second push
        '{2'd0,3'd0,7'h00,2'd0,1'b0,1'b0,1'b0,1'b1,8'h00, 1'b1,8'h4D,8'h08,1'b0,8'd7},  // R7 pop
        '{2'd1,3'd0,7'h13,2'd0,1'b1,1'b0,1'b0,1'b1,8'h00, 1'b1,8'h3C,8'h07,1'b0,8'd11}, // R11 pop beats read
        '{2'd1,3'd0,7'h20,2'd0,1'b0,1'b1,1'b1,1'b0,8'h99, 1'b0,8'h00,8'h08,1'b0,8'd11}, // R11 push beats write
        '{2'd1,3'd0,7'h20,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h00,8'h08,1'b0,8'd11}, // R11 20h not written
        '{2'd1,3'd0,7'h08,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h99,8'h08,1'b0,8'd6},  // R6 push data stored
        '{2'd2,3'd0,7'h00,2'd1,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h00,8'h08,1'b1,8'd5},  // R5 bank 1 R0 = 99h
        '{2'd1,3'd0,7'h7F,2'd0,1'b0,1'b1,1'b0,1'b0,8'h6B, 1'b0,8'h00,8'h08,1'b0,8'd3},  // R3 top byte
        '{2'd0,3'd1,7'h00,2'd2,1'b0,1'b1,1'b0,1'b0,8'h7F, 1'b0,8'h00,8'h08,1'b0,8'd4},  // R4 pointer R1 bank 2 = 7Fh
        '{2'd2,3'd1,7'h00,2'd2,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h6B,8'h08,1'b0,8'd4},  // R4 limit pointer served
        '{2'd1,3'd0,7'h30,2'd0,1'b0,1'b1,1'b0,1'b0,8'h12, 1'b0,8'h00,8'h08,1'b0,8'd9},  // R9 seed
        '{2'd1,3'd0,7'h30,2'd0,1'b1,1'b1,1'b0,1'b0,8'h34, 1'b1,8'h12,8'h08,1'b0,8'd9},  // R9 old value returned
        '{2'd1,3'd0,7'h30,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h34,8'h08,1'b0,8'd9},  // R9 new value stored
        '{2'd0,3'd0,7'h00,2'd0,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1,8'h34,8'h08,1'b0,8'd10}, // R10 idle hold
        '{2'd1,3'd0,7'h31,2'd0,1'b0,1'b1,1'b0,1'b0,8'h56, 1'b1,8'h34,8'h08,1'b0,8'd10}, // R10 write only hold
        '{2'd0,3'd7,7'h00,2'd3,1'b0,1'b1,1'b0,1'b0,8'hE1, 1'b0,8'h00,8'h08,1'b0,8'd2},  // R2 R7 bank 3
        '{2'd1,3'd0,7'h1F,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'hE1,8'h08,1'b0,8'd2},  // R2 at 1Fh
        '{2'd0,3'd7,7'h00,2'd1,1'b0,1'b1,1'b0,1'b0,8'hC3, 1'b0,8'h00,8'h08,1'b0,8'd2},  // R2 R7 bank 1
        '{2'd1,3'd0,7'h0F,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'hC3,8'h08,1'b0,8'd2},  // R2 at 0Fh
        '{2'd0,3'd7,7'h00,2'd1,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'hC3,8'h08,1'b0,8'd2}   // R2 register read
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] acc_mode = '0;
    logic [2:0] reg_idx = '0;
    logic [6:0] dir_addr = '0;
    logic [1:0] bank_sel = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       push_en = 1'b0;
    logic       pop_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] stack_ptr;
    logic       range_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    idata_bank_ram i_idata_bank_ram (
        .clk       (clk),
        .rst       (rst),
        .acc_mode  (acc_mode),
        .reg_idx   (reg_idx),
        .dir_addr  (dir_addr),
        .bank_sel  (bank_sel),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .push_en   (push_en),
        .pop_en    (pop_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .stack_ptr (stack_ptr),
        .range_err (range_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive one cycle of stimulus and return at the following falling edge
    task automatic drive(input logic [1:0] m, input logic [2:0] i, input logic [6:0] d,
                         input logic [1:0] b, input logic r, input logic w,
                         input logic pu, input logic po, input logic [7:0] wd);
        acc_mode = m; reg_idx = i; dir_addr = d; bank_sel = b;
        rd_en = r; wr_en = w; push_en = pu; pop_en = po; wr_data = wd;
        @(negedge clk);
    endtask

    task automatic idle();
        drive(2'd0, 3'd0, 7'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        idle();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 sp", stack_ptr, 8'h07);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 range_err", {7'd0, range_err}, 8'h00);

        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v].mode, VECS[v].idx, VECS[v].dir, VECS[v].bank, VECS[v].rd,
                  VECS[v].wr, VECS[v].push, VECS[v].pop, VECS[v].wd);
            chk($sformatf("R%0d vec%0d sp", VECS[v].req, v), stack_ptr, VECS[v].esp);
            chk($sformatf("R%0d R12 vec%0d err", VECS[v].req, v), {7'd0, range_err}, {7'd0, VECS[v].eerr});
            if (VECS[v].chk) begin
                chk($sformatf("R%0d vec%0d rd", VECS[v].req, v), rd_data, VECS[v].erd);
            end
        end

        // R1 mid-run reset clears pointer, outputs and RAM
        do_reset();
        chk("R1 sp after reset", stack_ptr, 8'h07);
        drive(2'd1, 3'd0, 7'h40, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R1 RAM cleared", rd_data, 8'h00);

        // R7 underflow wrap and R8 pop refusal
        drive(2'd1, 3'd0, 7'h00, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3E);
        for (int k = 0; k < 8; k++) begin
            drive(2'd0, 3'd0, 7'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        end
        chk("R7 pop at 00h data", rd_data, 8'h3E);
        chk("R7 pointer wraps to FFh", stack_ptr, 8'hFF);
        drive(2'd0, 3'd0, 7'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        chk("R8 refused pop data", rd_data, 8'h00);
        chk("R8 refused pop sp", stack_ptr, 8'hFF);
        chk("R8 R12 refused pop err", {7'd0, range_err}, 8'h01);
        drive(2'd0, 3'd0, 7'h00, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
        chk("R6 push from FFh sp", stack_ptr, 8'h00);
        chk("R12 err cleared", {7'd0, range_err}, 8'h00);
        drive(2'd1, 3'd0, 7'h00, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R6 push from FFh data", rd_data, 8'h5A);

        // R8 overflow at the top of the array
        for (int k = 0; k < 127; k++) begin
            drive(2'd0, 3'd0, 7'h00, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'(k));
        end
        chk("R6 pointer reaches 7Fh", stack_ptr, 8'h7F);
        drive(2'd0, 3'd0, 7'h00, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hEE);
        chk("R8 refused push sp", stack_ptr, 8'h7F);
        chk("R8 R12 refused push err", {7'd0, range_err}, 8'h01);
        drive(2'd0, 3'd0, 7'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        chk("R8 top byte not overwritten", rd_data, 8'h7E);
        chk("R7 pop from 7Fh sp", stack_ptr, 8'h7E);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule